// File: doc/BRIEF.md
# Serial audio frame transmitter

This block takes parallel audio samples from a small internal queue and sends them one bit at a time on a serial data line. A frame-sync pulse marks the start of each frame. Each frame carries one sample slot, sent most significant bit first. Any bit clocks left in the frame after the slot send zeros. The serial data changes on the falling edge of the bit clock, so a receiver samples it on the rising edge.

As bit-clock master, the block divides its system clock to make the bit clock. It can also output a master clock at half the system rate. The bit clock starts as soon as the block is enabled. Frame sync, however, waits until the queue holds a sample. After that, frames follow back to back, and a frame that finds the queue empty carries zeros and raises a sticky underrun flag.

As slave, the bit clock and frame sync arrive on input pins. They are synchronized into the system clock domain, and each detected rising edge of frame sync starts a frame. An optional link-controller setting lets the block drive frame sync itself while it takes the bit clock from its input. Dropping the enable lets the current frame finish, then parks every output low.

Top module: `audio_frame_tx`

## Requirements
- R1: After reset, bclk_out, fs_out, mclk_out and sd_out are 0, fifo_empty is 1, fifo_full is 0, and both underrun and overflow are 0.
- R2: Output enables follow the configuration.
  - When master is 1: bclk_oe is 1, fs_oe is 1, and mclk_oe equals mclk_en.
  - When master is 0: bclk_oe and mclk_oe are 0, and fs_oe equals fs_drive.
  - sd_oe equals tx_mode in both cases.
- R3: In master mode, the bit clock starts toggling when en is 1, even if the queue is empty. Each half period lasts bclk_div+1 system clocks. While mclk_en is 1, mclk_out toggles on every system clock.
- R4: In master mode, fs_out stays 0 until a sample has been written. The first frame then carries the first written sample, and later frames carry the later samples in write order.
- R5: Frame format:
  - fs_out is high for the first fs_width bit clocks of the frame.
  - A frame lasts frame_len bit clocks.
  - The slot sends bits [slot_width-1:0] of the sample, most significant bit first.
  - The remaining bit clocks of the frame send 0.
  - sd_out changes only when the bit clock falls.
- R6: If the queue is empty when a slot starts, the slot sends all zeros and underrun becomes 1. Underrun stays 1 until a cycle with flag_clr[0]=1 in which no new underrun occurs.
- R7: The queue holds 8 samples and reports fifo_full and fifo_empty. A write while fifo_full is 1 is discarded and sets overflow. Overflow stays 1 until flag_clr[1]=1.
- R8: In slave mode with fs_drive=0, each synchronized rising edge of fs_in starts a frame, and each falling edge of bclk_in moves to the next bit. Frames start whether or not the queue holds data.
- R9: In slave mode with fs_drive=1, the block takes the bit clock from bclk_in but drives fs_out itself. It frames exactly as in master mode, including the wait for the first sample.
- R10: When en falls, the current frame completes. The bit clock, frame sync and sd_out then stay 0, and no further samples leave the queue.
- R11: With tx_mode=0, no sample leaves the queue, sd_out stays 0 and underrun stays 0. In master mode the bit clock still runs while en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| master | input | 1 | 1: bit-clock master, 0: slave |
| tx_mode | input | 1 | 1: transmit, 0: receive (data pin released) |
| fs_drive | input | 1 | Slave only: drive frame sync as an output |
| mclk_en | input | 1 | Enable master clock output in master mode |
| bclk_div | input | 8 | Bit-clock half period minus one, in system clocks |
| frame_len | input | 8 | Bit clocks per frame |
| slot_width | input | 6 | Bits per slot, 1 to 32 |
| fs_width | input | 8 | Frame-sync active width in bit clocks |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 32 | Sample to write |
| flag_clr | input | 2 | Write-1 clear: bit 0 underrun, bit 1 overflow |
| bclk_in | input | 1 | Bit clock from an external master |
| fs_in | input | 1 | Frame sync from an external master |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit-clock pin output enable |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Frame-sync pin output enable |
| mclk_out | output | 1 | Master clock |
| mclk_oe | output | 1 | Master clock pin output enable |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data pin output enable |
| fifo_full | output | 1 | Queue holds 8 samples |
| fifo_empty | output | 1 | Queue holds no sample |
| underrun | output | 1 | Sticky empty-slot flag |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
In master mode, sd_out and fs_out change on the same system clock edge on which bclk_out falls. The bench therefore reads each data bit at the following rising edge of the bit clock, bclk_div+1 clocks later, instead of counting cycles from the write. In slave mode the input synchronizer and edge detector add about three system clocks after a bclk_in edge. The bench holds each half period of bclk_in for six clocks, so a bit is settled by the time it is read at the next rising edge. Output enables depend only on the configuration inputs and are checked one time step after a change. Flags and queue levels settle one clock after the event, and the bench reads them at falling clock edges.

// File: rtl/aft_pkg.sv
package aft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } frm_state_e;

  localparam int unsigned CLR_UDR = 0;
  localparam int unsigned CLR_OVF = 1;
endpackage

// File: rtl/aft_fifo.sv
module aft_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] mem_q [DEPTH];
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ok   = wr_en & ~full;
  assign rd_ok   = rd_en & ~empty;
  assign drop    = wr_en & full;
  assign rd_data = mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_ok) wptr_d = ptr_inc(wptr_q);
    if (rd_ok) rptr_d = ptr_inc(rptr_q);
    case ({wr_ok, rd_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q] <= wr_data;
  end

  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);
endmodule

// File: rtl/aft_bitclk.sv
module aft_bitclk #(
  parameter int unsigned DIVW = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master,
  input  logic            run,
  input  logic            mclk_run,
  input  logic [DIVW-1:0] div_half,
  input  logic            bclk_pin,
  input  logic            fs_pin,
  output logic            bclk_o,
  output logic            mclk_o,
  output logic            fall_tick,
  output logic            fs_rise
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            bclk_q, bclk_d;
  logic            mclk_q, mclk_d;
  logic [SYNC-1:0] bsync_q, bsync_d, fsync_q, fsync_d;
  logic            bprev_q, fprev_q;
  logic            gen_on, tick, s_fall, s_rise_fs;

  assign gen_on = run & master;
  assign tick   = gen_on & (cnt_q == div_half);

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!gen_on) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + DIVW'(1);
    end
    mclk_d = mclk_run ? ~mclk_q : 1'b0;
  end

  generate
    if (SYNC > 1) begin : g_chain
      assign bsync_d = {bsync_q[SYNC-2:0], bclk_pin};
      assign fsync_d = {fsync_q[SYNC-2:0], fs_pin};
    end else begin : g_single
      assign bsync_d = bclk_pin;
      assign fsync_d = fs_pin;
    end
  endgenerate

  assign s_fall    = bprev_q & ~bsync_q[SYNC-1];
  assign s_rise_fs = ~fprev_q & fsync_q[SYNC-1];

  assign bclk_o    = bclk_q;
  assign mclk_o    = mclk_q;
  assign fall_tick = master ? (tick & bclk_q) : s_fall;
  assign fs_rise   = ~master & s_rise_fs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bclk_q  <= 1'b0;
      mclk_q  <= 1'b0;
      bsync_q <= '0;
      fsync_q <= '0;
      bprev_q <= 1'b0;
      fprev_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      bclk_q  <= bclk_d;
      mclk_q  <= mclk_d;
      bsync_q <= bsync_d;
      fsync_q <= fsync_d;
      bprev_q <= bsync_q[SYNC-1];
      fprev_q <= fsync_q[SYNC-1];
    end
  end

  assert_bclk_parks_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bclk_o);
endmodule

// File: rtl/aft_framer.sv
module aft_framer
  import aft_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned FLW = 8,
  parameter int unsigned SWW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           self_timed,
  input  logic           fall_tick,
  input  logic           fs_rise,
  input  logic           fifo_empty,
  input  logic [DW-1:0]  fifo_word,
  input  logic [FLW-1:0] frame_len,
  input  logic [SWW-1:0] slot_width,
  input  logic [FLW-1:0] fs_width,
  output logic           pop,
  output logic           udr_set,
  output logic           sd_o,
  output logic           fs_o,
  output logic           in_frame
);
  frm_state_e     state_q, state_d;
  logic [FLW-1:0] bitcnt_q, bitcnt_d;
  logic [DW-1:0]  shreg_q, shreg_d;
  logic [SWW-1:0] shamt;
  logic           load, adv, last_bit, ext_start;

  assign shamt     = SWW'(DW) - slot_width;
  assign last_bit  = (bitcnt_q == (frame_len - FLW'(1)));
  assign ext_start = ~self_timed & fs_rise & arm;

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    load     = 1'b0;
    adv      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (arm) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!arm) state_d = ST_IDLE;
        else if (self_timed ? (fall_tick & ~fifo_empty) : fs_rise) load = 1'b1;
      end
      ST_RUN: begin
        if (ext_start) begin
          load = 1'b1;
        end else if (fall_tick) begin
          if (last_bit) begin
            if (!arm)           state_d = ST_IDLE;
            else if (self_timed) load   = 1'b1;
            else                 state_d = ST_WAIT;
          end else begin
            adv = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) begin
      state_d  = ST_RUN;
      bitcnt_d = '0;
      shreg_d  = fifo_empty ? '0 : (fifo_word << shamt);
    end
    if (adv) begin
      bitcnt_d = bitcnt_q + FLW'(1);
      shreg_d  = shreg_q << 1;
    end
  end

  assign pop      = load & ~fifo_empty;
  assign udr_set  = load & fifo_empty;
  assign in_frame = (state_q == ST_RUN);
  assign sd_o     = in_frame & (int'(bitcnt_q) < int'(slot_width)) & shreg_q[DW-1];
  assign fs_o     = self_timed & in_frame & (bitcnt_q < fs_width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
    end
  end

  assert_fs_starts_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_o) |-> $past(pop || udr_set));
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import aft_pkg::*;
#(
  parameter  int unsigned DW    = 32,
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned DIVW  = 8,
  parameter  int unsigned FLW   = 8,
  parameter  int unsigned SYNC  = 2,
  localparam int unsigned SWW   = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            master,
  input  logic            tx_mode,
  input  logic            fs_drive,
  input  logic            mclk_en,
  input  logic [DIVW-1:0] bclk_div,
  input  logic [FLW-1:0]  frame_len,
  input  logic [SWW-1:0]  slot_width,
  input  logic [FLW-1:0]  fs_width,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      flag_clr,
  input  logic            bclk_in,
  input  logic            fs_in,
  output logic            bclk_out,
  output logic            bclk_oe,
  output logic            fs_out,
  output logic            fs_oe,
  output logic            mclk_out,
  output logic            mclk_oe,
  output logic            sd_out,
  output logic            sd_oe,
  output logic            fifo_full,
  output logic            fifo_empty,
  output logic            underrun,
  output logic            overflow
);
  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic          arm, self_timed, clk_run, mclk_run;
  logic          pop, udr_set, ovf_set, in_frame, fall_tick, fs_rise;
  logic [DW-1:0] fifo_word;
  logic          udr_q, udr_d, ovf_q, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign arm        = en & tx_mode;
  assign self_timed = master | fs_drive;
  assign clk_run    = en | in_frame;
  assign mclk_run   = master & mclk_en & clk_run;

  aft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (fifo_word),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .drop    (ovf_set)
  );

  aft_bitclk #(.DIVW(DIVW), .SYNC(SYNC)) u_bitclk (
    .clk       (clk),
    .rst_n     (rst_ni),
    .master    (master),
    .run       (clk_run),
    .mclk_run  (mclk_run),
    .div_half  (bclk_div),
    .bclk_pin  (bclk_in),
    .fs_pin    (fs_in),
    .bclk_o    (bclk_out),
    .mclk_o    (mclk_out),
    .fall_tick (fall_tick),
    .fs_rise   (fs_rise)
  );

  aft_framer #(.DW(DW), .FLW(FLW), .SWW(SWW)) u_framer (
    .clk        (clk),
    .rst_n      (rst_ni),
    .arm        (arm),
    .self_timed (self_timed),
    .fall_tick  (fall_tick),
    .fs_rise    (fs_rise),
    .fifo_empty (fifo_empty),
    .fifo_word  (fifo_word),
    .frame_len  (frame_len),
    .slot_width (slot_width),
    .fs_width   (fs_width),
    .pop        (pop),
    .udr_set    (udr_set),
    .sd_o       (sd_out),
    .fs_o       (fs_out),
    .in_frame   (in_frame)
  );

  always_comb begin
    udr_d = (udr_q & ~flag_clr[CLR_UDR]) | udr_set;
    ovf_d = (ovf_q & ~flag_clr[CLR_OVF]) | ovf_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      udr_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      udr_q <= udr_d;
      ovf_q <= ovf_d;
    end
  end

  assign underrun = udr_q;
  assign overflow = ovf_q;
  assign bclk_oe  = master;
  assign fs_oe    = self_timed;
  assign mclk_oe  = master & mclk_en;
  assign sd_oe    = tx_mode;

  assert_udr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    udr_set |=> underrun);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_set |=> overflow);
  assert_pop_only_tx_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> tx_mode);
endmodule

// File: tb/sim_audio_frame_tx.sv
`timescale 1ns/1ps
module sim_audio_frame_tx;
  logic        clk, rst_n, en, master, tx_mode, fs_drive, mclk_en;
  logic [7:0]  bclk_div, frame_len, fs_width;
  logic [5:0]  slot_width;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [1:0]  flag_clr;
  logic        bclk_in, fs_in;
  logic        bclk_out, bclk_oe, fs_out, fs_oe, mclk_out, mclk_oe, sd_out, sd_oe;
  logic        fifo_full, fifo_empty, underrun, overflow;

  audio_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .tx_mode(tx_mode),
    .fs_drive(fs_drive), .mclk_en(mclk_en), .bclk_div(bclk_div),
    .frame_len(frame_len), .slot_width(slot_width), .fs_width(fs_width),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .bclk_in(bclk_in), .fs_in(fs_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
    .fs_out(fs_out), .fs_oe(fs_oe), .mclk_out(mclk_out), .mclk_oe(mclk_oe),
    .sd_out(sd_out), .sd_oe(sd_oe), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .underrun(underrun), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          n_cmp, n_bad;
  bit          done;
  logic [31:0] exp_q[$];
  string       mon_req;
  bit          mon_on;
  int          mon_bit, mon_frames;
  logic [31:0] mon_word;
  logic        mon_fs_prev;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_mask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // Monitor: collects one slot per frame at rising bit-clock edges and compares
  wire mon_bclk = master ? bclk_out : bclk_in;
  wire mon_fs   = (master | fs_drive) ? fs_out : fs_in;
  always @(posedge mon_bclk) begin
    logic [31:0] e;
    #1;
    if (mon_on) begin
      if (mon_fs && !mon_fs_prev) begin
        mon_bit = 0;
        mon_word = '0;
        mon_frames++;
      end
      if (mon_bit < int'(slot_width)) begin
        mon_word = {mon_word[30:0], sd_out};
        mon_bit++;
        if (mon_bit == int'(slot_width)) begin
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
          e = e & slot_mask(int'(slot_width));
          chk(mon_word == e, mon_req, "slot word", mon_word, e);
        end
      end else if (mon_bit < 1000) begin
        chk(sd_out == 1'b0, "R5", "pad bit", sd_out, 0);
      end
    end
    mon_fs_prev = mon_fs;
  end

  // Driver: writes samples and pushes the expected ones into the scoreboard
  task automatic write_words(input int n, input logic [31:0] base, input int push_n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = base ^ (32'h1357_9BDF * (i + 1));
      if (i < push_n) exp_q.push_back(wr_data);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; master = 1'b1; tx_mode = 1'b1; fs_drive = 1'b0;
    mclk_en = 1'b0; bclk_div = 8'd1; frame_len = 8'd12; slot_width = 6'd8;
    fs_width = 8'd3; wr_en = 1'b0; wr_data = '0; flag_clr = 2'b00;
    bclk_in = 1'b1; fs_in = 1'b0;
    mon_on = 1'b0; mon_bit = 1000; mon_frames = 0; mon_fs_prev = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [1:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = 2'b00;
    @(negedge clk);
  endtask

  task automatic count_bclk_rises(input int cycles, output int rises);
    logic p;
    rises = 0;
    p = bclk_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bclk_out && !p) rises++;
      p = bclk_out;
    end
  endtask

  task automatic measure_frame(output int w, output int len);
    logic p;
    w = 0; len = 0; p = 1'b1;
    @(posedge fs_out);
    forever begin
      @(posedge bclk_out); #1;
      if (fs_out && !p) break;
      len++;
      if (fs_out) w++;
      p = fs_out;
    end
  endtask

  task automatic slave_clock(input int frames, input int flen, input bit with_fs);
    for (int f = 0; f < frames; f++) begin
      for (int b = 0; b < flen; b++) begin
        @(negedge clk);
        bclk_in = 1'b0;
        fs_in = with_fs && (b == 0);
        repeat (6) @(negedge clk);
        bclk_in = 1'b1;
        repeat (5) @(negedge clk);
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int r, w, len, tog;
    time t0, t1;
    logic pm;
    n_cmp = 0; n_bad = 0; done = 0;

    // R1 reset state
    do_reset();
    chk(bclk_out == 0 && fs_out == 0 && mclk_out == 0 && sd_out == 0, "R1", "pins low",
        {bclk_out, fs_out, mclk_out, sd_out}, 0);
    chk(fifo_empty == 1 && fifo_full == 0, "R1", "queue flags", {fifo_empty, fifo_full}, 2'b10);
    chk(underrun == 0 && overflow == 0, "R1", "sticky flags", {underrun, overflow}, 0);

    // R2 output enables
    master = 1; mclk_en = 1; tx_mode = 1; #1;
    chk({bclk_oe, fs_oe, mclk_oe, sd_oe} == 4'b1111, "R2", "master oe",
        {bclk_oe, fs_oe, mclk_oe, sd_oe}, 4'b1111);
    master = 0; fs_drive = 0; #1;
    chk({bclk_oe, fs_oe, mclk_oe} == 3'b000, "R2", "slave oe", {bclk_oe, fs_oe, mclk_oe}, 0);
    fs_drive = 1; tx_mode = 0; #1;
    chk({fs_oe, sd_oe} == 2'b10, "R2", "drive fs, rx", {fs_oe, sd_oe}, 2'b10);

    // R3 / R4 / R5 / R6 master run
    do_reset();
    mclk_en = 1; mon_req = "R4";
    @(negedge clk); en = 1;
    count_bclk_rises(100, r);
    chk(r >= 24 && r <= 26, "R3", "bclk rises with empty queue", r, 25);
    chk(fs_out == 0, "R4", "fs held off", fs_out, 0);
    @(posedge bclk_out); t0 = $time;
    @(negedge bclk_out); t1 = $time;
    chk((t1 - t0) == 20, "R3", "half period ns", t1 - t0, 20);
    tog = 0; @(negedge clk); pm = mclk_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (mclk_out != pm) tog++; pm = mclk_out;
    end
    chk(tog == 20, "R3", "mclk toggles", tog, 20);
    mon_on = 1;
    write_words(5, 32'hA5C3_0F11, 5);
    measure_frame(w, len);
    chk(w == 3, "R5", "fs width", w, 3);
    chk(len == 12, "R5", "frame length", len, 12);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all samples sent", exp_q.size(), 0);
    chk(underrun == 1, "R6", "underrun set", underrun, 1);
    @(negedge clk); en = 0;
    repeat (120) @(negedge clk);
    clear_flags(2'b01);
    chk(underrun == 0, "R6", "underrun cleared", underrun, 0);
    count_bclk_rises(50, r);
    chk(r == 0 && fs_out == 0 && sd_out == 0, "R10", "stopped after disable", r, 0);

    // R10 disable mid frame
    do_reset();
    mon_req = "R10";
    write_words(3, 32'h0000_00C9, 1);
    @(negedge clk); en = 1; mon_on = 1;
    @(posedge fs_out);
    @(negedge clk); en = 0;
    repeat (150) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "current frame completed", exp_q.size(), 0);
    chk(fifo_empty == 0, "R10", "no pop after disable", fifo_empty, 0);
    count_bclk_rises(50, r);
    chk(r == 0 && sd_out == 0, "R10", "bclk parked", r, 0);

    // R7 overflow and ordering
    do_reset();
    mon_req = "R7";
    write_words(9, 32'h5A5A_1234, 8);
    chk(fifo_full == 1 && fifo_empty == 0, "R7", "queue full", fifo_full, 1);
    chk(overflow == 1, "R7", "overflow set", overflow, 1);
    clear_flags(2'b10);
    chk(overflow == 0, "R7", "overflow cleared", overflow, 0);
    @(negedge clk); en = 1; mon_on = 1;
    repeat (470) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "eight samples in order", exp_q.size(), 0);
    chk(fifo_empty == 1, "R7", "queue drained", fifo_empty, 1);

    // R11 receive mode
    do_reset();
    write_words(1, 32'hFFFF_FFFF, 0);
    tx_mode = 0;
    @(negedge clk); en = 1;
    r = 0; w = 0; pm = bclk_out;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (sd_out) w++;
      if (bclk_out && !pm) r++;
      pm = bclk_out;
    end
    chk(w == 0, "R11", "sd quiet", w, 0);
    chk(r > 0, "R11", "bclk runs", r, 1);
    chk(fifo_empty == 0 && underrun == 0 && sd_oe == 0, "R11", "no pop/underrun",
        {fifo_empty, underrun, sd_oe}, 0);

    // R8 slave framing
    do_reset();
    master = 0; slot_width = 6'd16; frame_len = 8'd20; mon_req = "R8";
    write_words(2, 32'h00BE_EF00, 2);
    @(negedge clk); en = 1; mon_on = 1;
    slave_clock(4, 20, 1'b1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "slave samples sent", exp_q.size(), 0);
    chk(mon_frames == 4, "R8", "frames seen", mon_frames, 4);
    chk(underrun == 1, "R8", "empty slave slots underrun", underrun, 1);

    // R9 slave clock, block-driven frame sync
    do_reset();
    master = 0; fs_drive = 1; fs_width = 8'd2; mon_req = "R9";
    write_words(2, 32'h0000_0096, 2);
    @(negedge clk); en = 1; mon_on = 1;
    #1;
    chk(fs_oe == 1 && bclk_oe == 0, "R9", "oe", {fs_oe, bclk_oe}, 2'b10);
    slave_clock(4, 12, 1'b0);
    chk(exp_q.size() == 0, "R9", "samples sent", exp_q.size(), 0);
    chk(mon_frames >= 3, "R9", "frames from own fs", mon_frames, 3);

    done = 1;
    finish_run();
  end
endmodule